// File: doc/BRIEF.md
# Stereo Codec and SRAM Frame Sequencer

This block handles one stereo frame for each sample strobe. It exchanges a 16-bit left sample and a 16-bit right sample with an audio codec as four full-duplex bytes. The bytes go through an external SPI byte engine that runs in mode 0 with MSB first. Between byte transfers it reads playback samples from an external asynchronous SRAM and stores the freshly captured samples there.

The sequencer drives the SRAM address, the active-low chip and write enables, and a bidirectional 16-bit data bus. A separate address generator supplies a base read address and a base write address. The left word uses the base address and the right word uses the base address plus one. After reset the sequencer first writes zero to every memory word, so playback starts silent, and only then accepts strobes.

The byte engine is expected to hold its received byte stable from its completion pulse until the next start request.

Top module: `stereo_frame_seq`

## Requirements
- R1: During and after reset, select, start request and overrun are low and write enable is high. The first frame after the clear sweep transmits four zero bytes.
- R2: After reset every memory word from 0 to 2^ADDR_W-1 is written with zero exactly once. This clear sweep finishes before the first select pulse.
- R3: A frame begins with the select line high for exactly one cycle. The first start request follows in the next cycle with select low. A start request is never issued while select is high.
- R4: A frame sends four bytes, each with a one-cycle start request: playback left high byte, left low byte, right high byte, right low byte. No start request is issued until the completion pulse of the previous byte has been seen.
- R5: Received bytes 0 and 1 form the captured left word {b0,b1}. Received bytes 2 and 3 form the captured right word {b2,b3}.
- R6: Memory accesses in a frame occur in this order: read at R, write captured left at W, read at R+1, write captured right at W+1. Addresses wrap modulo 2^ADDR_W. The read of left follows the second start request, the write of left follows the third, the read of right follows the fourth, and the write of right follows the fourth completion.
- R7: A write cycle sets the address with chip enable low and write enable high. It then pulls write enable low for one cycle with the address held and data driven, and returns write enable high while the data is still driven. The bus is released on the following cycle.
- R8: A read cycle holds write enable high and chip enable low for two cycles with the address stable, and it samples the bus at the end of the second cycle.
- R9: The bytes sent in a frame are the words read from memory during the previous frame.
- R10: A strobe that arrives during the clear sweep or during a frame is ignored, and the overrun output pulses high for one cycle in the cycle after it.
- R11: The read and write base addresses are captured when an accepted strobe arrives. Later changes during the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_strobe | input | 1 | One-cycle request to run a frame |
| rd_base | input | ADDR_W | Base playback address from the address generator |
| wr_base | input | ADDR_W | Base capture address from the address generator |
| strobe_overrun | output | 1 | One-cycle pulse when a strobe was ignored |
| codec_sel | output | 1 | Codec frame select pulse |
| spi_go | output | 1 | Start request for one byte transfer |
| spi_tx_byte | output | 8 | Byte to transmit, valid with spi_go |
| spi_done | input | 1 | One-cycle byte completion pulse from the engine |
| spi_rx_byte | input | 8 | Received byte, held from spi_done to next spi_go |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq | inout | 16 | SRAM data bus, two byte lanes |

## Verification
If the sequencer loses its place in the frame, the error shows up at the SPI side on the next start request. A byte then arrives out of order, or a start request appears before the previous completion, so a scoreboard that compares every transmitted byte catches it within one frame. Wrong addressing or wrong byte pairing inside memory stays hidden until a later frame plays those words back. For that reason the bench also compares the whole memory model with its reference at the end. A write strobe without driven data appears as unknown bits in the stored word at the moment write enable rises.

// File: rtl/sfs_pkg.sv
// Package: shared state type for the stereo frame sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sfs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_GO,
        ST_WAIT,
        ST_RD_A,
        ST_RD_S,
        ST_WR_A,
        ST_WR_P,
        ST_WR_E
    } seq_state_t;
endpackage

// File: rtl/sfs_sequencer.sv
// Module: frame schedule state machine. Starts in the clear sweep after
// reset, then runs select, four byte transfers and four memory cycles
// per accepted strobe. Assumes spi_done arrives at least one cycle after
// the matching start request.
module sfs_sequencer
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              spi_done,
    output seq_state_t        state,
    output logic [1:0]        byte_idx,
    output logic              clearing,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              overrun,
    output logic              capture,
    output logic              frame_end
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic done_seen;

    assign capture   = (state == ST_WAIT) && done_seen;
    assign frame_end = (state == ST_WR_E) && !clearing && (byte_idx == 2'd3);

    // Completion latch: remembers a done pulse that lands during a memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 done_seen <= 1'b0;
        else if (state == ST_GO)    done_seen <= 1'b0;
        else if (spi_done)          done_seen <= 1'b1;
    end

    // Overrun pulse: flags a strobe seen while not idle.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= strobe && (state != ST_IDLE);
    end

    // Main schedule: clear sweep, then the fixed frame order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WR_A;
            clearing <= 1'b1;
            clr_addr <= '0;
            byte_idx <= 2'd0;
        end else begin
            unique case (state)
                ST_IDLE: if (strobe) begin
                    state    <= ST_SEL;
                    byte_idx <= 2'd0;
                end
                ST_SEL:  state <= ST_GO;
                ST_GO: begin
                    unique case (byte_idx)
                        2'd0:    state <= ST_WAIT;
                        2'd2:    state <= ST_WR_A;
                        default: state <= ST_RD_A;
                    endcase
                end
                ST_RD_A: state <= ST_RD_S;
                ST_RD_S: state <= ST_WAIT;
                ST_WAIT: if (done_seen) begin
                    if (byte_idx == 2'd3) state <= ST_WR_A;
                    else begin
                        byte_idx <= byte_idx + 2'd1;
                        state    <= ST_GO;
                    end
                end
                ST_WR_A: state <= ST_WR_P;
                ST_WR_P: state <= ST_WR_E;
                ST_WR_E: begin
                    if (clearing) begin
                        if (clr_addr == LAST_ADDR) begin
                            clearing <= 1'b0;
                            state    <= ST_IDLE;
                        end else begin
                            clr_addr <= clr_addr + 1'b1;
                            state    <= ST_WR_A;
                        end
                    end else if (byte_idx == 2'd3) state <= ST_IDLE;
                    else                           state <= ST_WAIT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfs_samples.sv
// Module: sample registers. Collects received bytes, holds the words
// fetched this frame and the words being played, and picks the byte to send.
// Assumes byte_idx selects both the byte slot and the channel (3 = right).
module sfs_samples #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              fetch,
    input  logic              frame_end,
    input  logic [1:0]        byte_idx,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [WORD_W-1:0] rd_word,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [WORD_W-1:0] cap_left,
    output logic [WORD_W-1:0] cap_right
);
    logic [BYTE_W-1:0] rx_q [4];
    logic [WORD_W-1:0] fetch_l, fetch_r, play_l, play_r;

    // Received byte slots, one per transfer position.
    for (genvar g = 0; g < 4; g++) begin : g_rx
        always_ff @(posedge clk) begin
            if (!rst_n)                                   rx_q[g] <= '0;
            else if (capture && byte_idx == 2'(g))        rx_q[g] <= rx_byte;
        end
    end

    assign cap_left  = {rx_q[0], rx_q[1]};
    assign cap_right = {rx_q[2], rx_q[3]};

    // Fetched words: filled by the two read cycles of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_l <= '0;
            fetch_r <= '0;
        end else if (fetch) begin
            if (byte_idx == 2'd3) fetch_r <= rd_word;
            else                  fetch_l <= rd_word;
        end
    end

    // Playback words: handed over at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_l <= '0;
            play_r <= '0;
        end else if (frame_end) begin
            play_l <= fetch_l;
            play_r <= fetch_r;
        end
    end

    // Transmit byte selection in fixed frame order.
    always_comb begin
        unique case (byte_idx)
            2'd0:    tx_byte = play_l[WORD_W-1:BYTE_W];
            2'd1:    tx_byte = play_l[BYTE_W-1:0];
            2'd2:    tx_byte = play_r[WORD_W-1:BYTE_W];
            default: tx_byte = play_r[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/sfs_sram_port.sv
// Module: SRAM control decode. Turns the schedule state into address,
// enables, drive enable and write data. Assumes bases are held for the frame.
module sfs_sram_port
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 16
) (
    input  seq_state_t        state,
    input  logic              clearing,
    input  logic [1:0]        byte_idx,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [WORD_W-1:0] cap_left,
    input  logic [WORD_W-1:0] cap_right,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              we_n,
    output logic              drive,
    output logic [WORD_W-1:0] wdata
);
    logic              right, reading;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    // Address and control decode for the current memory cycle.
    always_comb begin
        right   = (byte_idx == 2'd3);
        reading = (state == ST_RD_A) || (state == ST_RD_S);
        rd_addr = rd_base + ADDR_W'(right);
        wr_addr = clearing ? clr_addr : wr_base + ADDR_W'(right);
        addr    = reading ? rd_addr : wr_addr;
        ce_n    = !(reading || state == ST_WR_A || state == ST_WR_P || state == ST_WR_E);
        we_n    = (state != ST_WR_P);
        drive   = (state == ST_WR_P) || (state == ST_WR_E);
        wdata   = clearing ? '0 : (right ? cap_right : cap_left);
    end
endmodule

// File: rtl/stereo_frame_seq.sv
// Module: top of the stereo codec and SRAM frame sequencer. Captures the
// base addresses on an accepted strobe, drives the byte engine and the
// SRAM bus. Assumes an external SPI byte engine (mode 0, MSB first).
module stereo_frame_seq
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_strobe,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] wr_base,
    output logic              strobe_overrun,
    output logic              codec_sel,
    output logic              spi_go,
    output logic [BYTE_W-1:0] spi_tx_byte,
    input  logic              spi_done,
    input  logic [BYTE_W-1:0] spi_rx_byte,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    inout  wire  [WORD_W-1:0] sram_dq
);
    seq_state_t        state;
    logic [1:0]        byte_idx;
    logic              clearing, capture, frame_end, drive;
    logic [ADDR_W-1:0] clr_addr, rd_q, wr_q;
    logic [WORD_W-1:0] cap_left, cap_right, wdata;

    sfs_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .spi_done(spi_done),
        .state(state), .byte_idx(byte_idx), .clearing(clearing),
        .clr_addr(clr_addr), .overrun(strobe_overrun), .capture(capture),
        .frame_end(frame_end)
    );

    // Base address capture on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (sample_strobe && state == ST_IDLE) begin
            rd_q <= rd_base;
            wr_q <= wr_base;
        end
    end

    sfs_samples #(.BYTE_W(BYTE_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .fetch(state == ST_RD_S), .frame_end(frame_end), .byte_idx(byte_idx),
        .rx_byte(spi_rx_byte), .rd_word(sram_dq), .tx_byte(spi_tx_byte),
        .cap_left(cap_left), .cap_right(cap_right)
    );

    sfs_sram_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .state(state), .clearing(clearing), .byte_idx(byte_idx),
        .clr_addr(clr_addr), .rd_base(rd_q), .wr_base(wr_q),
        .cap_left(cap_left), .cap_right(cap_right), .addr(sram_addr),
        .ce_n(sram_ce_n), .we_n(sram_we_n), .drive(drive), .wdata(wdata)
    );

    assign codec_sel = (state == ST_SEL);
    assign spi_go    = (state == ST_GO);
    assign sram_dq   = drive ? wdata : 'z;

    // R7
    we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);
    // R7
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);
    // R7
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> $stable(sram_addr) && $past(!sram_ce_n));
    // R7
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> drive);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive && sram_we_n |=> !drive);
    // R3
    sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        codec_sel |=> !codec_sel && spi_go);
    // R3
    go_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spi_go && codec_sel));
    // R10
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_overrun |-> $past(sample_strobe));
endmodule

// File: tb/stereo_frame_seq_bench.sv
// Bench: scoreboard of transmitted bytes plus an SRAM and byte-engine model.
module stereo_frame_seq_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic [AW-1:0] rd_base = '0, wr_base = '0;
    logic          overrun, sel, go, spi_done;
    logic [7:0]    tx_byte, rx_byte;
    logic [AW-1:0] addr;
    logic          ce_n, we_n;
    wire  [15:0]   dq;

    int tests = 0, fails = 0, cycles = 0;
    int sel_count = 0, ovr_count = 0, wr_count = 0;
    bit first_sel_seen = 0;

    logic [15:0] mem [DEPTH];
    logic [15:0] ref_mem [DEPTH];
    logic [7:0]  exp_tx [$];
    logic [7:0]  rx_q [$];
    logic [15:0] pend_l = '0, pend_r = '0;
    logic        we_was_low = 1'b0;
    int          eng_cnt = 0;

    always #4 clk = ~clk;

    stereo_frame_seq #(.ADDR_W(AW)) u_stereo_frame_seq (
        .clk(clk), .rst_n(rst_n), .sample_strobe(strobe), .rd_base(rd_base),
        .wr_base(wr_base), .strobe_overrun(overrun), .codec_sel(sel),
        .spi_go(go), .spi_tx_byte(tx_byte), .spi_done(spi_done),
        .spi_rx_byte(rx_byte), .sram_addr(addr), .sram_ce_n(ce_n),
        .sram_we_n(we_n), .sram_dq(dq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // SRAM model: drives reads, stores a word when write enable returns high.
    assign dq = (!ce_n && we_n && !we_was_low) ? mem[addr] : 'z;
    always @(posedge clk) begin
        we_was_low <= !we_n;
        if (we_was_low) begin
            check(!$isunknown(dq), "R7", {16'h0, dq}, 32'h0);
            mem[addr] <= dq;
            wr_count  <= wr_count + 1;
        end
    end

    // Byte engine model: completes each byte three cycles after its start.
    always @(posedge clk) begin
        if (!rst_n) begin
            spi_done <= 1'b0; rx_byte <= '0; eng_cnt <= 0;
        end else begin
            spi_done <= 1'b0;
            if (go) eng_cnt <= 3;
            else if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) begin
                    spi_done <= 1'b1;
                    rx_byte  <= rx_q.pop_front();
                end
            end
        end
    end

    // Monitor: compares each transmitted byte and tracks select and overrun.
    always @(negedge clk) begin
        if (rst_n) begin
            if (go) begin
                check(eng_cnt == 0, "R4", eng_cnt, 0);
                if (exp_tx.size() == 0) check(1'b0, "R4", {24'h0, tx_byte}, 32'hFFFF);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(tx_byte == e, "R9", {24'h0, tx_byte}, {24'h0, e});
                end
            end
            if (sel) begin
                sel_count++;
                if (!first_sel_seen) begin
                    first_sel_seen = 1;
                    check(wr_count == DEPTH, "R2", wr_count, DEPTH);
                    for (int i = 0; i < DEPTH; i++)
                        check(mem[i] == 16'h0, "R2", {16'h0, mem[i]}, 0);
                end
            end
            if (overrun) ovr_count++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Driver: predicts one frame, pushes expected bytes, then strobes.
    task automatic run_frame(input logic [AW-1:0] rd, input logic [AW-1:0] wr,
                             input logic [15:0] l, input logic [15:0] r,
                             input bit extra_strobe);
        logic [15:0] nl, nr;
        int s0;
        s0 = sel_count;
        exp_tx.push_back(pend_l[15:8]); exp_tx.push_back(pend_l[7:0]);
        exp_tx.push_back(pend_r[15:8]); exp_tx.push_back(pend_r[7:0]);
        rx_q.push_back(l[15:8]); rx_q.push_back(l[7:0]);
        rx_q.push_back(r[15:8]); rx_q.push_back(r[7:0]);
        // R6 order: read R, write W, read R+1, write W+1
        nl = ref_mem[rd];
        ref_mem[wr] = l;
        nr = ref_mem[AW'(rd + 1)];
        ref_mem[AW'(wr + 1)] = r;
        pend_l = nl; pend_r = nr;
        rd_base = rd; wr_base = wr; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        // R11: scramble the bases mid-frame
        rd_base = ~rd; wr_base = ~wr;
        repeat (10) @(negedge clk);
        if (extra_strobe) begin
            int o0;
            o0 = ovr_count;
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            @(negedge clk);
            check(ovr_count == o0 + 1, "R10", ovr_count, o0 + 1);
        end
        repeat (50) @(negedge clk);
        check(sel_count == s0 + 1, "R3", sel_count, s0 + 1);
        check(exp_tx.size() == 0, "R4", exp_tx.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 16'hA5A5;
            ref_mem[i] = 16'h0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!sel && !go && !overrun && we_n, "R1", {sel, go, overrun, we_n}, 4'b0001);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R10 strobe during clear is ignored
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        check(ovr_count == 1, "R10", ovr_count, 1);
        repeat (DEPTH * 3 + 10) @(negedge clk);
        check(sel_count == 0, "R10", sel_count, 0);
        // R1 first frame sends zeros (pend starts at zero)
        run_frame(6'd0, 6'd10, 16'h1234, 16'h5678, 0);
        run_frame(6'd10, 6'd20, 16'hABCD, 16'hEF01, 0);   // R5 R9 replay
        run_frame(6'd20, 6'd20, 16'h0F0F, 16'hF0F0, 1);   // R6 read before write, R10
        run_frame(6'd30, 6'd31, 16'h1111, 16'h2222, 0);   // R6 right read sees new left
        run_frame(6'd63, 6'd63, 16'h3344, 16'h5566, 0);   // R6 wrap
        run_frame(6'd63, 6'd5, 16'h7788, 16'h99AA, 0);
        run_frame(6'd5, 6'd40, 16'hFFFF, 16'h0000, 0);
        run_frame(6'd40, 6'd41, 16'h0102, 16'h0304, 0);
        // R5 R6 R8 memory contents match reference
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] === ref_mem[i], "R6", {16'h0, mem[i]}, {16'h0, ref_mem[i]});
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule